// File: doc/BRIEF.md
# Transfer Descriptor Status Update Unit

This block sits between the descriptor fetch path and the memory write port of a frame-list style host controller. For each presented descriptor it takes the 32-bit control word, the 32-bit token word and a transaction outcome. The outcome is either a byte count from a finished transfer, a handshake or error indication, or a marker that the transaction is still outstanding.

From these it forms the new control word and a write-back enable. It also produces a result code that tells the schedule walker whether to advance, retry, wait or abandon the frame. Two interrupt-cause bits go to the frame-end interrupt collector, along with pulses for the error status and the process-error status. The token is also split into its fields for the walker and the packet engine.

The unit is a single pipeline stage. A descriptor accepted with `in_valid` in one cycle has its results on the outputs after the next rising edge, qualified by `out_valid`.

Top module: `td_status_wb`

## Requirements
- R1: While reset is held and before any descriptor is accepted, `out_valid`, `wb_en`, `int_cause`, `usb_err` and `proc_err` are all 0.
- R2: The token splits into PID = bits 7:0, device = bits 14:8 and endpoint = bits 18:15. The maximum length is (bits 31:21 + 1) taken modulo 2048, so a field of 0x7FF gives 0.
- R3: A descriptor whose active bit (control bit 23) is 0 gives result 1 (skip). Its control word is returned unchanged, with no write-back and no interrupt cause.
- R4: An active descriptor whose PID is not 0x2D (setup), 0x69 (in) or 0xE1 (out) gives result 4 (fatal) and raises `proc_err`. Its control word is unchanged and there is no write-back.
- R5: An outcome code of 5, 6 or 7 means the transaction is pending. It gives result 2, an unchanged control word, no write-back and no interrupt cause.
- R6: Outcome 0 (data) writes (byte count − 1) modulo 2048 into control bits 10:0 and clears active (bit 23) and NAK (bit 19). When no other rule applies the result is 0 (done).
- R7: With outcome 0, an IN PID and a byte count above the maximum length, the babble rule of R10 is applied after the length write of R6.
- R8: With outcome 0, short-packet detect (bit 29) set and a byte count below the maximum length, the result is 3 (short, queue not advanced) and `int_cause[1]` is set.
- R9: Outcome 1 (stall) sets bit 22, clears active and gives result 1.
- R10: Outcome 2 (babble) sets bits 20 and 22, clears active and gives result 4.
- R11: Outcome 3 (NAK) sets bit 19, leaves active as it was and gives result 1.
- R12: Outcome 4 (timeout) sets bit 18 and gives result 1. A nonzero error count in bits 28:27 is decremented. If it reaches 0, active is cleared and `usb_err` pulses. A count of 0 stays 0 and retries without limit.
- R13: For any outcome 0 to 4, interrupt-on-complete (bit 24) sets `int_cause[0]`, and isochronous select (bit 25) clears active.
- R14: `wb_en` is 1 exactly when the accepted descriptor's new control word differs from the fetched one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor and outcome presented this cycle |
| ctrl_word | input | 32 | Fetched descriptor control word |
| token_word | input | 32 | Fetched descriptor token word |
| outcome | input | 3 | 0 data, 1 stall, 2 babble, 3 NAK, 4 timeout, 5-7 pending |
| byte_cnt | input | CNT_W | Bytes moved, used with outcome 0 |
| out_valid | output | 1 | Results below belong to an accepted descriptor |
| ctrl_next | output | 32 | Updated control word |
| wb_en | output | 1 | Control word must be written back |
| result | output | 3 | 0 done, 1 skip, 2 pending, 3 short, 4 fatal |
| int_cause | output | 2 | Bit 0 completion interrupt, bit 1 short-packet interrupt |
| usb_err | output | 1 | Error count ran out this descriptor |
| proc_err | output | 1 | Unknown PID seen |
| tok_pid | output | 8 | Decoded PID |
| tok_dev | output | 7 | Decoded device address |
| tok_ep | output | 4 | Decoded endpoint |
| tok_maxlen | output | 11 | Decoded maximum length |

## Verification
Directed descriptors cover each branch in turn. These include an inactive word with every other bit set, a foreign PID, each pending code, and byte counts equal to, one below and one above the maximum length for IN and OUT PIDs. They also cover a zero byte count, a maximum-length field of 0x7FF, and timeouts starting from each error count. The equal/below/above byte counts separate the done, short and babble paths. The error-count sweep separates the decrement, the exhaustion and the unlimited-retry cases. Random control and token words, with an active bit and valid PIDs weighted in, then combine interrupt-on-complete, isochronous select and stale status bits with every outcome. This shows whether a bit is kept or cleared by the right rule, and whether `wb_en` follows a real change only.

// File: rtl/td_status_wb_pkg.sv
package td_status_wb_pkg;

  // control word bit positions
  localparam int unsigned C_SPD    = 29;
  localparam int unsigned C_ERR_LO = 27;
  localparam int unsigned C_ISO    = 25;
  localparam int unsigned C_IOC    = 24;
  localparam int unsigned C_ACT    = 23;
  localparam int unsigned C_STALL  = 22;
  localparam int unsigned C_BABBLE = 20;
  localparam int unsigned C_NAK    = 19;
  localparam int unsigned C_TMO    = 18;
  localparam int unsigned LEN_W    = 11;

  // token field positions
  localparam int unsigned T_DEV_LO = 8;
  localparam int unsigned T_DEV_W  = 7;
  localparam int unsigned T_EP_LO  = 15;
  localparam int unsigned T_EP_W   = 4;
  localparam int unsigned T_MAX_LO = 21;

  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;

  typedef enum logic [2:0] {
    OC_DATA   = 3'd0,
    OC_STALL  = 3'd1,
    OC_BABBLE = 3'd2,
    OC_NAK    = 3'd3,
    OC_TMO    = 3'd4
  } outcome_e;

  typedef enum logic [2:0] {
    RS_DONE  = 3'd0,
    RS_SKIP  = 3'd1,
    RS_PEND  = 3'd2,
    RS_SHORT = 3'd3,
    RS_FATAL = 3'd4
  } result_e;

endpackage

// File: rtl/td_token_dec.sv
module td_token_dec
  import td_status_wb_pkg::*;
(
  input  logic [31:0]        token,
  output logic [7:0]         pid,
  output logic [T_DEV_W-1:0] dev,
  output logic [T_EP_W-1:0]  ep,
  output logic [LEN_W-1:0]   max_len,
  output logic               pid_known
);
  logic [LEN_W-1:0] max_field;

  always_comb begin
    pid       = token[7:0];
    dev       = token[T_DEV_LO +: T_DEV_W];
    ep        = token[T_EP_LO +: T_EP_W];
    max_field = token[T_MAX_LO +: LEN_W];
    max_len   = max_field + LEN_W'(1);
    pid_known = (pid == PID_SETUP) || (pid == PID_IN) || (pid == PID_OUT);
  end
endmodule

// File: rtl/td_ctrl_update.sv
module td_ctrl_update
  import td_status_wb_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic [31:0]      ctrl_in,
  input  logic [7:0]       pid,
  input  logic             pid_known,
  input  logic [LEN_W-1:0] max_len,
  input  logic [2:0]       outcome,
  input  logic [CNT_W-1:0] byte_cnt,
  output logic [31:0]      ctrl_out,
  output result_e          res,
  output logic [1:0]       cause,
  output logic             err_out,
  output logic             perr_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] max_ext;
  logic [CNT_W-1:0] len_m1;
  logic [1:0]       err_cnt;

  always_comb begin
    max_ext  = CNT_W'(max_len);
    len_m1   = byte_cnt - ONE;
    ctrl_out = ctrl_in;
    res      = RS_SKIP;
    cause    = 2'b00;
    err_out  = 1'b0;
    perr_out = 1'b0;
    err_cnt  = ctrl_in[C_ERR_LO +: 2];

    if (!ctrl_in[C_ACT]) begin
      res = RS_SKIP;
    end else if (!pid_known) begin
      res      = RS_FATAL;
      perr_out = 1'b1;
    end else if (outcome > 3'(OC_TMO)) begin
      res = RS_PEND;
    end else begin
      if (ctrl_in[C_IOC]) cause[0] = 1'b1;
      if (ctrl_in[C_ISO]) ctrl_out[C_ACT] = 1'b0;
      case (outcome)
        3'(OC_DATA): begin
          ctrl_out[LEN_W-1:0] = len_m1[LEN_W-1:0];
          ctrl_out[C_ACT]     = 1'b0;
          ctrl_out[C_NAK]     = 1'b0;
          if ((pid == PID_IN) && (byte_cnt > max_ext)) begin
            ctrl_out[C_BABBLE] = 1'b1;
            ctrl_out[C_STALL]  = 1'b1;
            res                = RS_FATAL;
          end else if (ctrl_in[C_SPD] && (byte_cnt < max_ext)) begin
            res      = RS_SHORT;
            cause[1] = 1'b1;
          end else begin
            res = RS_DONE;
          end
        end
        3'(OC_STALL): begin
          ctrl_out[C_STALL] = 1'b1;
          ctrl_out[C_ACT]   = 1'b0;
          res               = RS_SKIP;
        end
        3'(OC_BABBLE): begin
          ctrl_out[C_BABBLE] = 1'b1;
          ctrl_out[C_STALL]  = 1'b1;
          ctrl_out[C_ACT]    = 1'b0;
          res                = RS_FATAL;
        end
        3'(OC_NAK): begin
          ctrl_out[C_NAK] = 1'b1;
          res             = RS_SKIP;
        end
        default: begin
          ctrl_out[C_TMO] = 1'b1;
          if (err_cnt != 2'd0) begin
            err_cnt = err_cnt - 2'd1;
            if (err_cnt == 2'd0) begin
              ctrl_out[C_ACT] = 1'b0;
              err_out         = 1'b1;
            end
          end
          ctrl_out[C_ERR_LO +: 2] = err_cnt;
          res                     = RS_SKIP;
        end
      endcase
    end
  end
endmodule

// File: rtl/td_status_wb.sv
module td_status_wb
  import td_status_wb_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      ctrl_word,
  input  logic [31:0]      token_word,
  input  logic [2:0]       outcome,
  input  logic [CNT_W-1:0] byte_cnt,
  output logic             out_valid,
  output logic [31:0]      ctrl_next,
  output logic             wb_en,
  output logic [2:0]       result,
  output logic [1:0]       int_cause,
  output logic             usb_err,
  output logic             proc_err,
  output logic [7:0]       tok_pid,
  output logic [6:0]       tok_dev,
  output logic [3:0]       tok_ep,
  output logic [10:0]      tok_maxlen
);
  logic [7:0]         dec_pid;
  logic [T_DEV_W-1:0] dec_dev;
  logic [T_EP_W-1:0]  dec_ep;
  logic [LEN_W-1:0]   dec_max;
  logic               dec_known;

  logic [31:0] upd_ctrl;
  result_e     upd_res;
  logic [1:0]  upd_cause;
  logic        upd_err;
  logic        upd_perr;

  logic        wb_d, err_d, perr_d;
  logic [1:0]  cause_d;

  td_token_dec u_dec (
    .token     (token_word),
    .pid       (dec_pid),
    .dev       (dec_dev),
    .ep        (dec_ep),
    .max_len   (dec_max),
    .pid_known (dec_known)
  );

  td_ctrl_update #(.CNT_W(CNT_W)) u_upd (
    .ctrl_in  (ctrl_word),
    .pid      (dec_pid),
    .pid_known(dec_known),
    .max_len  (dec_max),
    .outcome  (outcome),
    .byte_cnt (byte_cnt),
    .ctrl_out (upd_ctrl),
    .res      (upd_res),
    .cause    (upd_cause),
    .err_out  (upd_err),
    .perr_out (upd_perr)
  );

  // next-state for the per-descriptor pulses
  always_comb begin
    wb_d    = in_valid && (upd_ctrl != ctrl_word);
    cause_d = in_valid ? upd_cause : 2'b00;
    err_d   = in_valid && upd_err;
    perr_d  = in_valid && upd_perr;
  end

  // pulse and valid registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      int_cause <= 2'b00;
      usb_err   <= 1'b0;
      proc_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= wb_d;
      int_cause <= cause_d;
      usb_err   <= err_d;
      proc_err  <= perr_d;
    end
  end

  // data registers, loaded on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_next  <= '0;
      result     <= '0;
      tok_pid    <= '0;
      tok_dev    <= '0;
      tok_ep     <= '0;
      tok_maxlen <= '0;
    end else if (in_valid) begin
      ctrl_next  <= upd_ctrl;
      result     <= 3'(upd_res);
      tok_pid    <= dec_pid;
      tok_dev    <= dec_dev;
      tok_ep     <= dec_ep;
      tok_maxlen <= dec_max;
    end
  end
endmodule

// File: rtl/td_status_wb_chk.sv
module td_status_wb_chk
  import td_status_wb_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      ctrl_word,
  input logic [31:0]      token_word,
  input logic [2:0]       outcome,
  input logic [CNT_W-1:0] byte_cnt,
  input logic             out_valid,
  input logic [31:0]      ctrl_next,
  input logic             wb_en,
  input logic [2:0]       result,
  input logic [1:0]       int_cause,
  input logic             usb_err,
  input logic             proc_err,
  input logic [7:0]       tok_pid,
  input logic [6:0]       tok_dev,
  input logic [3:0]       tok_ep,
  input logic [10:0]      tok_maxlen
);
  logic pid_ok;
  assign pid_ok = (token_word[7:0] == PID_SETUP) || (token_word[7:0] == PID_IN) ||
                  (token_word[7:0] == PID_OUT);

  // R14: write-back only for an accepted descriptor whose word changed
  a_r14_wb_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> out_valid && (ctrl_next != $past(ctrl_word)));

  // R3: inactive descriptor is skipped untouched
  a_r3_inactive_skip: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ctrl_word[C_ACT] |=> result == 3'(RS_SKIP) && !wb_en && int_cause == 2'b00);

  // R4: unknown PID is fatal
  a_r4_bad_pid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ctrl_word[C_ACT] && !pid_ok |=> proc_err && result == 3'(RS_FATAL) && !wb_en);

  // R5: pending leaves the word alone
  a_r5_pending: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ctrl_word[C_ACT] && pid_ok && outcome > 3'd4 |=> result == 3'(RS_PEND) && !wb_en);

  // R10: babble outcome
  a_r10_babble: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ctrl_word[C_ACT] && pid_ok && outcome == 3'(OC_BABBLE) |=>
      result == 3'(RS_FATAL) && ctrl_next[C_BABBLE] && ctrl_next[C_STALL] && !ctrl_next[C_ACT]);

  // R11: NAK keeps a non-isochronous descriptor active
  a_r11_nak_active: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ctrl_word[C_ACT] && !ctrl_word[C_ISO] && pid_ok && outcome == 3'(OC_NAK) |=>
      ctrl_next[C_NAK] && ctrl_next[C_ACT]);

  // R12: error exhaustion leaves an inactive word with zero count
  a_r12_err_exhaust: assert property (@(posedge clk) disable iff (!rst_n)
    usb_err |-> !ctrl_next[C_ACT] && ctrl_next[C_ERR_LO +: 2] == 2'd0 && ctrl_next[C_TMO]);

  // R1: nothing reported without an accepted descriptor
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !wb_en && !usb_err && !proc_err && int_cause == 2'b00);
endmodule

bind td_status_wb td_status_wb_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/td_status_wb_tb_top.sv
module td_status_wb_tb_top;
  localparam int unsigned CNT_W = 12;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic [31:0]      ctrl_word;
  logic [31:0]      token_word;
  logic [2:0]       outcome;
  logic [CNT_W-1:0] byte_cnt;
  logic             out_valid;
  logic [31:0]      ctrl_next;
  logic             wb_en;
  logic [2:0]       result;
  logic [1:0]       int_cause;
  logic             usb_err;
  logic             proc_err;
  logic [7:0]       tok_pid;
  logic [6:0]       tok_dev;
  logic [3:0]       tok_ep;
  logic [10:0]      tok_maxlen;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 0;

  td_status_wb #(.CNT_W(CNT_W)) dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, actual=%0d expected=<100000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit pid_valid(input logic [7:0] p);
    return p == 8'h2D || p == 8'h69 || p == 8'hE1;
  endfunction

  function automatic void expect_of(
    input  logic [31:0] c, input logic [31:0] t, input logic [2:0] oc,
    input  logic [CNT_W-1:0] n,
    output logic [31:0] ec, output logic [2:0] er, output logic [1:0] ei,
    output logic eu, output logic ep);
    logic [10:0] mx;
    logic [1:0]  e;
    mx = t[31:21] + 11'd1;
    ec = c; er = 3'd1; ei = 2'b00; eu = 1'b0; ep = 1'b0;
    if (!c[23]) return;
    if (!pid_valid(t[7:0])) begin er = 3'd4; ep = 1'b1; return; end
    if (oc >= 3'd5) begin er = 3'd2; return; end
    ei[0] = c[24];
    if (c[25]) ec[23] = 1'b0;
    case (oc)
      3'd0: begin
        ec[10:0] = 11'(n - 1);
        ec[23] = 1'b0; ec[19] = 1'b0;
        if (t[7:0] == 8'h69 && n > CNT_W'(mx)) begin ec[20] = 1'b1; ec[22] = 1'b1; er = 3'd4; end
        else if (c[29] && n < CNT_W'(mx)) begin er = 3'd3; ei[1] = 1'b1; end
        else er = 3'd0;
      end
      3'd1: begin ec[22] = 1'b1; ec[23] = 1'b0; end
      3'd2: begin ec[20] = 1'b1; ec[22] = 1'b1; ec[23] = 1'b0; er = 3'd4; end
      3'd3: ec[19] = 1'b1;
      default: begin
        ec[18] = 1'b1;
        e = c[28:27];
        if (e != 0) begin
          e = e - 1;
          if (e == 0) begin ec[23] = 1'b0; eu = 1'b1; end
        end
        ec[28:27] = e;
      end
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] c, input logic [31:0] t,
                     input logic [2:0] oc, input logic [CNT_W-1:0] n);
    logic [31:0] ec; logic [2:0] er; logic [1:0] ei; logic eu, ep;
    expect_of(c, t, oc, n, ec, er, ei, eu, ep);
    @(negedge clk);
    in_valid = 1'b1; ctrl_word = c; token_word = t; outcome = oc; byte_cnt = n;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, "out_valid", 32'(out_valid), 32'd1);
    chk(tag, "ctrl_next", ctrl_next, ec);
    chk(tag, "result", 32'(result), 32'(er));
    chk(tag, "int_cause", 32'(int_cause), 32'(ei));
    chk(tag, "usb_err", 32'(usb_err), 32'(eu));
    chk(tag, "proc_err", 32'(proc_err), 32'(ep));
    chk(tag, "wb_en", 32'(wb_en), 32'(ec != c));
    chk(tag, "tok_fields", {tok_maxlen, tok_ep, tok_dev, tok_pid},
        {t[31:21] + 11'd1, t[18:15], t[14:8], t[7:0]});
  endtask

  function automatic logic [31:0] tok(input logic [7:0] p, input logic [10:0] mfield);
    return {mfield, 2'b00, 4'd5, 7'd17, p};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; ctrl_word = '0; token_word = '0; outcome = '0; byte_cnt = '0;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid", 32'(out_valid), 32'd0);
    chk("R1", "wb_en", 32'(wb_en), 32'd0);
    chk("R1", "pulses", {int_cause, usb_err, proc_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle_after_release", {out_valid, wb_en, int_cause, usb_err, proc_err}, 32'd0);

    run("R2", 32'h0080_0000, 32'hFFE0_0069, 3'd5, 12'd0);
    run("R2", 32'h0080_0000, 32'h0007_FFE1, 3'd5, 12'd0);
    run("R3", 32'hFF7F_FFFF, tok(8'h69, 11'd63), 3'd0, 12'd10);
    run("R4", 32'h0080_0000, tok(8'hA5, 11'd63), 3'd0, 12'd10);
    run("R5", 32'h2180_0000, tok(8'hE1, 11'd63), 3'd5, 12'd10);
    run("R5", 32'h0180_0000, tok(8'h2D, 11'd7), 3'd7, 12'd3);
    run("R6", 32'h0088_0000, tok(8'hE1, 11'd63), 3'd0, 12'd64);
    run("R6", 32'h0080_0000, tok(8'hE1, 11'd63), 3'd0, 12'd0);
    run("R7", 32'h0080_0000, tok(8'h69, 11'd63), 3'd0, 12'd65);
    run("R7", 32'h0080_0000, tok(8'hE1, 11'd63), 3'd0, 12'd65);
    run("R7", 32'h0080_0000, tok(8'h69, 11'h7FF), 3'd0, 12'd1);
    run("R8", 32'h2080_0000, tok(8'h69, 11'd63), 3'd0, 12'd63);
    run("R8", 32'h2080_0000, tok(8'h69, 11'd63), 3'd0, 12'd64);
    run("R9", 32'h0080_0000, tok(8'h2D, 11'd7), 3'd1, 12'd0);
    run("R10", 32'h0080_0000, tok(8'h69, 11'd7), 3'd2, 12'd0);
    run("R11", 32'h0080_0000, tok(8'h69, 11'd7), 3'd3, 12'd0);
    run("R11", 32'h0088_0000, tok(8'h69, 11'd7), 3'd3, 12'd0);
    for (int e = 0; e < 4; e++)
      run("R12", 32'h0080_0000 | (32'(e) << 27), tok(8'hE1, 11'd7), 3'd4, 12'd0);
    run("R13", 32'h0180_0000, tok(8'hE1, 11'd7), 3'd0, 12'd8);
    run("R13", 32'h0280_0000, tok(8'h69, 11'd7), 3'd3, 12'd0);
    run("R14", 32'h0080_0007, tok(8'hE1, 11'd7), 3'd3, 12'd0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] c, t; logic [2:0] oc; logic [CNT_W-1:0] n;
      c = $urandom;
      if ($urandom_range(0, 3) != 0) c[23] = 1'b1;
      t = $urandom;
      case ($urandom_range(0, 4))
        0: t[7:0] = 8'h2D;
        1, 2: t[7:0] = 8'h69;
        3: t[7:0] = 8'hE1;
        default: ;
      endcase
      if ($urandom_range(0, 1) == 1) t[31:21] = 11'($urandom_range(0, 70));
      oc = 3'($urandom_range(0, 7));
      n = CNT_W'(32'(t[31:21]) + 1 + $urandom_range(0, 4) - 2);
      if ($urandom_range(0, 5) == 0) n = CNT_W'($urandom);
      run("R14", c, t, oc, n);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule